// File: doc/BRIEF.md
# Strided Vector Memory Address Generator with Interleaved Banks

This block runs the memory side of vector loads and stores. A command supplies a base word address, a stride, an element count and two flags. One flag picks a store or a load. The other picks strided or indexed (gather) addressing. The block then presents at most one element request per cycle on a shared address and data bus. The bus serves sixteen word-interleaved banks, and the low four bits of the word address select the bank. Every bank access takes eleven cycles. The block keeps a busy window for each bank and holds the next element in place while its bank is still occupied. The stride therefore sets the sustained rate. A unit stride runs at one element per cycle, and a stride of 0 or 16 runs at one element every eleven cycles.

Element data comes from a vector register read port that the block indexes with the element number it is issuing. This port supplies the gather offset and the store data. Load responses come back over the shared bus in request order, a fixed bank latency after each request. The block forwards each response to a vector register write port, tagged with its element number. When the last response has come back, it raises a single-cycle completion pulse.

Top module: `vec_bank_agu`

## Requirements
- R1: In strided mode the first element request carries address `cmd_base`. On every request, `mem_bank` equals `mem_addr[3:0]`, which is the word address modulo 16.
- R2: In strided mode (`cmd_gather`=0), element k requests address `cmd_base + k*cmd_stride` modulo 2^16. The stride is unsigned, so 16'hFFFF walks downward. Exactly `cmd_len` requests are made, in element order.
- R3: In gather mode (`cmd_gather`=1), `elem_sel` shows the element k being requested, and element k requests address `cmd_base + elem_offset` modulo 2^16. Here `elem_offset` is the index value presented for element k in its request cycle.
- R4: At most one request is made per cycle. A bank that receives a request in cycle t receives no further request before cycle t+11.
- R5: If the bank of the next element is still busy, issue holds. That element is requested in the first cycle its bank is free, and no element is skipped or reordered.
- R6: Let a command be accepted in cycle s. When the elements fall in distinct free banks (stride 1, length at most 16), element k is requested in cycle s+1+k. For a load of N elements, `done` pulses in cycle s+N+12.
- R7: With a stride of 0 or 16, consecutive requests are exactly 11 cycles apart.
- R8: For a load (`cmd_store`=0), each response (`rsp_valid`) is written out in the next cycle with `vr_we`=1. `vr_idx` counts 0,1,2,... in return order, and `vr_wdata` equals the response data.
- R9: For a store (`cmd_store`=1), each request has `mem_we`=1 and `mem_wdata` equal to `elem_wdata` for the element shown on `elem_sel`. A store makes no `vr_we` write.
- R10: `done` is a one-cycle pulse in the cycle after the last response. `busy` is high in the cycle after acceptance and low in the `done` cycle.
- R11: `cmd_valid` is ignored while `busy` is high.
- R12: A command with `cmd_len`=0 makes no request and pulses `done` in cycle s+2.
- R13: Under reset, `mem_req`, `vr_we`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_gather | input | 1 | 1 = indexed addressing, 0 = strided |
| cmd_base | input | AW | Base word address |
| cmd_stride | input | AW | Word stride between elements |
| cmd_len | input | LENW | Element count, 0 to MAXLEN |
| busy | output | 1 | A command is in progress |
| elem_sel | output | IDXW | Element number being issued |
| elem_offset | input | AW | Gather offset for element `elem_sel` |
| elem_wdata | input | DW | Store data for element `elem_sel` |
| mem_req | output | 1 | Bank request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the request |
| mem_bank | output | BW | Target bank |
| mem_wdata | output | DW | Store data on the shared bus |
| rsp_valid | input | 1 | A bank access completes |
| rsp_rdata | input | DW | Read data of the completing access |
| vr_we | output | 1 | Vector register write strobe |
| vr_idx | output | IDXW | Element number written |
| vr_wdata | output | DW | Element data written |
| done | output | 1 | Command complete pulse |

## Verification
The assertions assume the memory side answers every request exactly once, in request order, a fixed eleven cycles later. They also assume no response appears outside a command or beyond its element count. The bench's behavioural bank model returns the word held at each address along a delay line of that length, and it never drives a response for anything but a real request. The bench also keeps each command's addresses within its 256-word model, and it sets the load and store regions apart so the expected read data follows from a fixed initial pattern.

// File: rtl/vagu_pkg.sv
// Shared types for the strided/gather vector address generator.
// Assumes nothing beyond being compiled before the modules that import it.
package vagu_pkg;

    // Direction of the vector memory access.
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    // How each element address is formed.
    typedef enum logic {
        AM_STRIDE = 1'b0,
        AM_GATHER = 1'b1
    } addr_mode_e;

endpackage

// File: rtl/vagu_bank_track.sv
// Per-bank occupancy tracker.
// Holds, for each bank, the number of cycles left before it may take a new
// access, and reports whether a queried bank is free this cycle.
// Assumes at most one issue per cycle and that the bank count is a power of two.
module vagu_bank_track #(
    parameter int NBANK    = 16,
    parameter int BANK_LAT = 11,
    parameter int BW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [BW-1:0] issue_bank_i,
    input  logic [BW-1:0] query_bank_i,
    output logic          free_o
);

    localparam int CW = $clog2(BANK_LAT + 1);

    logic [NBANK-1:0] free_vec;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CW-1:0] left_q;
        logic [CW-1:0] gap_q;

        // Count down the busy window of this bank, reload it on an issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                left_q <= '0;
            end else if (issue_i && issue_bank_i == BW'(g)) begin
                left_q <= CW'(BANK_LAT - 1);
            end else if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
        end

        assign free_vec[g] = (left_q == '0);

        // Checker state: cycles since the last issue to this bank, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q <= CW'(BANK_LAT);
            end else if (issue_i && issue_bank_i == BW'(g)) begin
                gap_q <= CW'(1);
            end else if (gap_q != CW'(BANK_LAT)) begin
                gap_q <= gap_q + 1'b1;
            end
        end

        AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_i && issue_bank_i == BW'(g)) |-> (gap_q == CW'(BANK_LAT))); // R4
    end

    assign free_o = free_vec[query_bank_i];

endmodule

// File: rtl/vagu_issue.sv
// Element issue unit.
// Captures a command, walks the element number, forms each element address
// (running stride sum or base plus gather offset), and issues one request in
// any cycle where the target bank is free. It stalls in place otherwise.
// Assumes the bank count is a power of two, so the bank is the low address bits.
module vagu_issue
    import vagu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int LENW = 7,
    parameter int IDXW = 6,
    parameter int BW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic            cmd_store_i,
    input  logic            cmd_gather_i,
    input  logic [AW-1:0]   cmd_base_i,
    input  logic [AW-1:0]   cmd_stride_i,
    input  logic [LENW-1:0] cmd_len_i,
    input  logic            busy_i,
    output logic            accept_o,
    output logic            run_o,
    output logic [IDXW-1:0] elem_sel_o,
    input  logic [AW-1:0]   elem_offset_i,
    input  logic [DW-1:0]   elem_wdata_i,
    input  logic            bank_free_i,
    output logic [BW-1:0]   bank_o,
    output logic            issue_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o
);

    acc_kind_e     kind_q;
    addr_mode_e    mode_q;
    logic          run_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] stride_q;
    logic [AW-1:0] walk_q;
    logic [LENW-1:0] len_q;
    logic [LENW-1:0] elem_q;
    logic [LENW-1:0] elem_next;
    logic [AW-1:0] cur_addr;
    logic          issue;

    assign accept_o  = cmd_valid_i && !busy_i;
    assign elem_next = elem_q + LENW'(1);

    // Select the address of the element now at the head of the walk.
    always_comb begin
        if (mode_q == AM_GATHER) begin
            cur_addr = base_q + elem_offset_i;
        end else begin
            cur_addr = walk_q;
        end
    end

    assign issue       = run_q && bank_free_i;
    assign bank_o      = cur_addr[BW-1:0];
    assign issue_o     = issue;
    assign run_o       = run_q;
    assign elem_sel_o  = elem_q[IDXW-1:0];
    assign mem_addr_o  = cur_addr;
    assign mem_we_o    = issue && (kind_q == ACC_STORE);
    assign mem_wdata_o = elem_wdata_i;

    // Load a new command, then advance one element per successful issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            kind_q   <= ACC_LOAD;
            mode_q   <= AM_STRIDE;
            base_q   <= '0;
            stride_q <= '0;
            walk_q   <= '0;
            len_q    <= '0;
            elem_q   <= '0;
        end else if (accept_o) begin
            run_q    <= (cmd_len_i != '0);
            kind_q   <= acc_kind_e'(cmd_store_i);
            mode_q   <= addr_mode_e'(cmd_gather_i);
            base_q   <= cmd_base_i;
            stride_q <= cmd_stride_i;
            walk_q   <= cmd_base_i;
            len_q    <= cmd_len_i;
            elem_q   <= '0;
        end else if (issue) begin
            elem_q <= elem_next;
            walk_q <= walk_q + stride_q;
            if (elem_next == len_q) begin
                run_q <= 1'b0;
            end
        end
    end

    AST_FIRST_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && elem_q == '0 && mode_q == AM_STRIDE) |-> (cur_addr == base_q)); // R1

    AST_STRIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && mode_q == AM_STRIDE && elem_q != '0 && $past(issue))
        |-> (cur_addr == $past(cur_addr) + stride_q)); // R2

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (elem_q < len_q)); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !issue) |=> ($stable(elem_q) && $stable(walk_q))); // R5

endmodule

// File: rtl/vagu_retire.sv
// Return sequencer.
// Counts responses of the active command, forwards load data to the vector
// register write port tagged with its element number, and pulses completion
// one cycle after the last response. Assumes responses arrive in request order.
module vagu_retire #(
    parameter int DW   = 32,
    parameter int LENW = 7,
    parameter int IDXW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic [LENW-1:0] accept_len_i,
    input  logic            accept_store_i,
    input  logic            rsp_valid_i,
    input  logic [DW-1:0]   rsp_rdata_i,
    output logic            active_o,
    output logic            vr_we_o,
    output logic [IDXW-1:0] vr_idx_o,
    output logic [DW-1:0]   vr_wdata_o,
    output logic            done_o
);

    logic            active_q;
    logic            store_q;
    logic [LENW-1:0] len_q;
    logic [LENW-1:0] cnt_q;
    logic [LENW-1:0] cnt_next;
    logic            finish;
    logic            vr_we_q;
    logic [IDXW-1:0] vr_idx_q;
    logic [DW-1:0]   vr_wdata_q;
    logic            done_q;

    assign cnt_next = cnt_q + LENW'(rsp_valid_i);
    assign finish   = active_q && (cnt_next == len_q);

    // Track the active command and its count of returned elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            store_q  <= 1'b0;
            len_q    <= '0;
            cnt_q    <= '0;
        end else if (accept_i) begin
            active_q <= 1'b1;
            store_q  <= accept_store_i;
            len_q    <= accept_len_i;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q <= cnt_next;
            if (finish) begin
                active_q <= 1'b0;
            end
        end
    end

    // Register the write port and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vr_we_q    <= 1'b0;
            vr_idx_q   <= '0;
            vr_wdata_q <= '0;
            done_q     <= 1'b0;
        end else begin
            vr_we_q    <= rsp_valid_i && active_q && !store_q;
            vr_idx_q   <= cnt_q[IDXW-1:0];
            vr_wdata_q <= rsp_rdata_i;
            done_q     <= finish;
        end
    end

    assign active_o   = active_q;
    assign vr_we_o    = vr_we_q;
    assign vr_idx_o   = vr_idx_q;
    assign vr_wdata_o = vr_wdata_q;
    assign done_o     = done_q;

    AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> (active_q && cnt_q < len_q)); // R8

    AST_WB_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we_q |-> $past(rsp_valid_i)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10

endmodule

// File: rtl/vec_bank_agu.sv
// Vector memory address generator over word-interleaved banks.
// Accepts one strided or gather command at a time, issues element requests
// paced by per-bank occupancy, and returns load data in element order.
// Assumes the bank side answers every request once, in order, BANK_LAT later.
module vec_bank_agu #(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int NBANK    = 16,
    parameter int BANK_LAT = 11,
    parameter int MAXLEN   = 64,
    localparam int BW      = $clog2(NBANK),
    localparam int LENW    = $clog2(MAXLEN + 1),
    localparam int IDXW    = $clog2(MAXLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic            cmd_store,
    input  logic            cmd_gather,
    input  logic [AW-1:0]   cmd_base,
    input  logic [AW-1:0]   cmd_stride,
    input  logic [LENW-1:0] cmd_len,
    output logic            busy,
    output logic [IDXW-1:0] elem_sel,
    input  logic [AW-1:0]   elem_offset,
    input  logic [DW-1:0]   elem_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [BW-1:0]   mem_bank,
    output logic [DW-1:0]   mem_wdata,
    input  logic            rsp_valid,
    input  logic [DW-1:0]   rsp_rdata,
    output logic            vr_we,
    output logic [IDXW-1:0] vr_idx,
    output logic [DW-1:0]   vr_wdata,
    output logic            done
);

    logic          accept;
    logic          run;
    logic          active;
    logic          issue;
    logic          bank_free;
    logic [BW-1:0] bank;

    assign busy     = run || active;
    assign mem_req  = issue;
    assign mem_bank = bank;

    vagu_issue #(
        .AW   (AW),
        .DW   (DW),
        .LENW (LENW),
        .IDXW (IDXW),
        .BW   (BW)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid_i   (cmd_valid),
        .cmd_store_i   (cmd_store),
        .cmd_gather_i  (cmd_gather),
        .cmd_base_i    (cmd_base),
        .cmd_stride_i  (cmd_stride),
        .cmd_len_i     (cmd_len),
        .busy_i        (busy),
        .accept_o      (accept),
        .run_o         (run),
        .elem_sel_o    (elem_sel),
        .elem_offset_i (elem_offset),
        .elem_wdata_i  (elem_wdata),
        .bank_free_i   (bank_free),
        .bank_o        (bank),
        .issue_o       (issue),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata)
    );

    vagu_bank_track #(
        .NBANK    (NBANK),
        .BANK_LAT (BANK_LAT),
        .BW       (BW)
    ) u_banks (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .issue_bank_i (bank),
        .query_bank_i (bank),
        .free_o       (bank_free)
    );

    vagu_retire #(
        .DW   (DW),
        .LENW (LENW),
        .IDXW (IDXW)
    ) u_retire (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept_i       (accept),
        .accept_len_i   (cmd_len),
        .accept_store_i (cmd_store),
        .rsp_valid_i    (rsp_valid),
        .rsp_rdata_i    (rsp_rdata),
        .active_o       (active),
        .vr_we_o        (vr_we),
        .vr_idx_o       (vr_idx),
        .vr_wdata_o     (vr_wdata),
        .done_o         (done)
    );

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> $stable(busy)); // R11

endmodule

// File: tb/vec_bank_agu_tb.sv
module vec_bank_agu_tb;

    localparam int AW = 16, DW = 32, NBANK = 16, LAT = 11, MAXLEN = 64;
    localparam int BW = 4, LENW = 7, IDXW = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic            cmd_valid, cmd_store, cmd_gather;
    logic [AW-1:0]   cmd_base, cmd_stride;
    logic [LENW-1:0] cmd_len;
    logic            busy;
    logic [IDXW-1:0] elem_sel;
    logic [AW-1:0]   elem_offset;
    logic [DW-1:0]   elem_wdata;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [BW-1:0]   mem_bank;
    logic [DW-1:0]   mem_wdata;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic            vr_we;
    logic [IDXW-1:0] vr_idx;
    logic [DW-1:0]   vr_wdata;
    logic            done;

    vec_bank_agu #(.AW(AW), .DW(DW), .NBANK(NBANK), .BANK_LAT(LAT), .MAXLEN(MAXLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_gather(cmd_gather), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_len(cmd_len), .busy(busy), .elem_sel(elem_sel), .elem_offset(elem_offset),
        .elem_wdata(elem_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_bank(mem_bank), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .vr_we(vr_we), .vr_idx(vr_idx), .vr_wdata(vr_wdata),
        .done(done)
    );

    // Stimulus table: base, stride, length, gather flag, store flag.
    typedef struct packed {
        logic [15:0] base;
        logic [15:0] stride;
        logic [6:0]  len;
        logic        gather;
        logic        store;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{16'h0010, 16'h0001, 7'd20, 1'b0, 1'b0},  // unit stride, no conflict
        '{16'h0003, 16'h0010, 7'd5,  1'b0, 1'b0},  // stride 16, one bank
        '{16'h0020, 16'h0000, 7'd4,  1'b0, 1'b0},  // stride 0, one bank
        '{16'h0005, 16'h0002, 7'd12, 1'b0, 1'b0},  // stride 2, eight banks
        '{16'h0040, 16'h0003, 7'd10, 1'b0, 1'b1},  // strided store
        '{16'h0080, 16'h0000, 7'd8,  1'b1, 1'b0},  // gather load
        '{16'hFFFE, 16'h0001, 7'd6,  1'b0, 1'b0},  // address wrap
        '{16'h0030, 16'hFFFF, 7'd7,  1'b0, 1'b0}   // downward stride
    };

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [31:0] init_val(input logic [7:0] a);
        return 32'hC0DE_0000 + 32'(a) * 32'd257;
    endfunction

    // Gather offsets and store data, read through the element select port.
    logic [15:0] idx_vec [MAXLEN];
    logic [31:0] src_vec [MAXLEN];
    assign elem_offset = idx_vec[elem_sel];
    assign elem_wdata  = src_vec[elem_sel];

    // Behavioural bank model: fixed latency, in-order responses.
    logic [31:0] bmem [256];
    logic        d_v [LAT];
    logic [31:0] d_d [LAT];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= init_val(8'(i));
            for (int i = 0; i < LAT; i++) begin
                d_v[i] <= 1'b0;
                d_d[i] <= '0;
            end
        end else begin
            d_v[0] <= mem_req;
            d_d[0] <= bmem[mem_addr[7:0]];
            for (int i = 1; i < LAT; i++) begin
                d_v[i] <= d_v[i-1];
                d_d[i] <= d_d[i-1];
            end
            if (mem_req && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        end
    end
    assign rsp_valid = d_v[LAT-1];
    assign rsp_rdata = d_d[LAT-1];

    // Monitor logs.
    int          req_n, vr_n, done_n, done_cyc;
    logic        done_busy;
    logic [15:0] req_addr [128];
    int          req_cyc  [128];
    int          req_sel  [128];
    logic        req_we   [128];
    logic [31:0] req_wd   [128];
    int          vr_idx_l [128];
    logic [31:0] vr_dat_l [128];
    int          vr_cyc_l [128];
    int          bank_bad;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && req_n < 128) begin
                req_addr[req_n] = mem_addr;
                req_cyc[req_n]  = cyc;
                req_sel[req_n]  = int'(elem_sel);
                req_we[req_n]   = mem_we;
                req_wd[req_n]   = mem_wdata;
                if (mem_bank != mem_addr[3:0]) bank_bad++;
                req_n++;
            end
            if (vr_we && vr_n < 128) begin
                vr_idx_l[vr_n] = int'(vr_idx);
                vr_dat_l[vr_n] = vr_wdata;
                vr_cyc_l[vr_n] = cyc;
                vr_n++;
            end
            if (done) begin
                done_n++;
                done_cyc  = cyc;
                done_busy = busy;
            end
        end
    end

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    // Expected schedule built from the requirements.
    logic [15:0] exp_addr [128];
    int          exp_t    [128];

    task automatic run_vec(input logic [15:0] base, input logic [15:0] stride, input int len,
                           input bit gather, input bit store, input bit intrude);
        int s, w, last, exp_done;
        int free_t [16];
        req_n = 0; vr_n = 0; done_n = 0; done_cyc = -1; bank_bad = 0; done_busy = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_base   = base;
        cmd_stride = stride;
        cmd_len    = LENW'(len);
        cmd_gather = gather;
        cmd_store  = store;
        s = cyc;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        // Expected issue cycles: one per cycle at most, bank busy for LAT cycles.
        for (int b = 0; b < 16; b++) free_t[b] = 0;
        last = s;
        for (int k = 0; k < len; k++) begin
            logic [15:0] a;
            int t;
            a = gather ? 16'(base + idx_vec[k]) : 16'(base + 16'(32'(stride) * k));
            t = (k == 0) ? s + 1 : exp_t[k-1] + 1;
            if (free_t[a[3:0]] > t) t = free_t[a[3:0]];
            free_t[a[3:0]] = t + LAT;
            exp_addr[k] = a;
            exp_t[k] = t;
            last = t;
        end
        exp_done = (len == 0) ? s + 2 : last + LAT + 1;
        w = 0;
        while (done_n == 0 && w < 3000) begin
            if (intrude && w == 2) begin
                cmd_valid = 1'b1;
                cmd_base  = 16'h0099;
                cmd_len   = 7'd3;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            #1;
            w++;
        end
        cmd_valid = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        chk(done_n == 1, "R10 single done pulse", done_n, 1);
        chk(done_cyc == exp_done, "R10 R12 done cycle", done_cyc, exp_done);
        chk(done_busy == 1'b0, "R10 busy low at done", done_busy, 0);
        chk(req_n == len, "R2 R11 R12 request count", req_n, len);
        chk(bank_bad == 0, "R1 bank equals address low bits", bank_bad, 0);
        for (int k = 0; k < len && k < req_n; k++) begin
            chk(req_addr[k] == exp_addr[k], "R1 R2 R3 element address", req_addr[k], exp_addr[k]);
            chk(req_cyc[k] == exp_t[k], "R4 R5 R6 R7 issue cycle", req_cyc[k], exp_t[k]);
            chk(req_sel[k] == k, "R3 element select", req_sel[k], k);
            chk(req_we[k] == store, "R9 write enable", req_we[k], store);
            if (store) chk(req_wd[k] == src_vec[k], "R9 store data", req_wd[k], src_vec[k]);
        end
        if (!gather && (stride == 16'd0 || stride == 16'd16)) begin
            for (int k = 1; k < req_n; k++)
                chk(req_cyc[k] - req_cyc[k-1] == LAT, "R7 single bank spacing",
                    req_cyc[k] - req_cyc[k-1], LAT);
        end
        if (!gather && stride == 16'd1 && len > 0 && len <= 16 && !store)
            chk(done_cyc - s == len + LAT + 1, "R6 unit stride latency", done_cyc - s, len + LAT + 1);
        if (store) begin
            chk(vr_n == 0, "R9 no writeback on store", vr_n, 0);
        end else begin
            chk(vr_n == len, "R8 writeback count", vr_n, len);
            for (int k = 0; k < len && k < vr_n; k++) begin
                chk(vr_idx_l[k] == k, "R8 writeback index", vr_idx_l[k], k);
                chk(vr_dat_l[k] == init_val(exp_addr[k][7:0]), "R8 writeback data",
                    vr_dat_l[k], init_val(exp_addr[k][7:0]));
                chk(vr_cyc_l[k] == exp_t[k] + LAT + 1, "R8 writeback cycle",
                    vr_cyc_l[k], exp_t[k] + LAT + 1);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R10 act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAXLEN; i++) begin
            idx_vec[i] = 16'((i * 5) % 23);
            src_vec[i] = 32'h5000_0000 + 32'(i) * 32'h11;
        end
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_store = 1'b0; cmd_gather = 1'b0;
        cmd_base = '0; cmd_stride = '0; cmd_len = '0;
        repeat (3) @(negedge clk);
        // R13: outputs quiet under reset.
        chk(mem_req == 1'b0, "R13 mem_req in reset", mem_req, 0);
        chk(vr_we == 1'b0, "R13 vr_we in reset", vr_we, 0);
        chk(done == 1'b0, "R13 done in reset", done, 0);
        chk(busy == 1'b0, "R13 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R13 idle after reset", busy, 0);

        for (int i = 0; i < 8; i++)
            run_vec(TABLE[i].base, TABLE[i].stride, int'(TABLE[i].len),
                    TABLE[i].gather, TABLE[i].store, 1'b0);

        // R11: a second command offered mid-run must be ignored.
        run_vec(16'h0060, 16'h0001, 8, 1'b0, 1'b0, 1'b1);
        // R12: empty command.
        run_vec(16'h0070, 16'h0001, 0, 1'b0, 1'b0, 1'b0);
        // R5 R7: longer single-bank run with stride 16.
        run_vec(16'h0007, 16'h0010, 9, 1'b0, 1'b0, 1'b0);
        // R6: full sixteen-bank sweep at one element per cycle.
        run_vec(16'h00A0, 16'h0001, 16, 1'b0, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule